// File: doc/BRIEF.md
# SHA-256 Block Hashing Peripheral

This block is a memory-mapped slave that computes the SHA-256 compression function over one 512-bit message block per command. Software loads sixteen 32-bit block words, then writes a control bit. One bit begins a fresh hash from the standard initial hash values. The other folds the loaded block into the digest left by the previous command. Software polls a status word until the engine is idle again and then reads eight digest words. Because the digest is kept between commands, software can read it after every block of a longer message.

The bus side is a single-cycle strobe interface. Each access is presented for one clock with strobe high, and write enable selects the direction. Read data, acknowledge and error are valid within that same cycle. The engine does one round per clock. It uses a sixteen-word rolling message schedule and an internal table of round constants. Message padding and length encoding are left to software.

Top module: `sha_hash_accel`

## Requirements
- R1: A read of word address 0x00 or 0x01 returns the eight-character ASCII identifier "hashcore", four characters per word, with the first character of each word in bits 31:24. A read of 0x02 returns the four-character version "v1.0".
- R2: Addresses 0x10 to 0x1F hold the message block and can be written and read back. 0x10 is block bits 511:480 and 0x1F is bits 31:0. Writing these addresses while a hash is running does not change the result of that hash.
- R3: When control bit 0 (init) rises, the engine hashes the loaded block starting from the standard SHA-256 initial values, whatever digest is already held. For the padded block "abc" the digest is BA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD. Digest word 0x20 holds bits 255:224 and 0x27 holds bits 31:0.
- R4: When control bit 1 (next) rises, the engine hashes the loaded block starting from the current digest. For the two-block message "abcdbcde...nopq", init on block one gives 85E655D6417A17953363376A624CDE5C76E09589CAC5F811CC4B32C1F20E533A. Next on block two (length word 0x1C0) then gives 248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1.
- R5: The control register is at 0x08. A command starts only when a written bit changes from 0 to 1 relative to the stored control value. Writing 1 again over a stored 1 starts nothing. A read of 0x08 returns the stored bits 1:0.
- R6: The status word at 0x09 has bit 0 = ready and bit 1 = digest valid, and reads 0x1 after reset. Both bits read 0 in the cycle after a command is accepted. Both are set again 65 clock edges after the accepting edge: 64 rounds and one fold into the chaining state.
- R7: The digest registers reset to zero and hold their value between commands.
- R8: A read of an unmapped address returns zero and raises error. A write to a read-only or unmapped address changes nothing and raises error. Every other strobed access raises acknowledge. Acknowledge and error are low when strobe is low.
- R9: A command written while the engine is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stb_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | 8 | Word address |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid in the strobe cycle |
| ack_o | output | 1 | Access accepted |
| err_o | output | 1 | Access refused (unmapped or read-only) |

## Verification
The bench builds the block with its default parameters: an 8-bit word address and the "hashcore"/"v1.0" identifier words. With the full 8-bit address, holes such as 0x05, 0x30 and 0x44 are reachable, so the error path can be exercised on both sides of the mapped windows. With the fixed 64-round schedule, the bench can count the exact number of busy polls. Known-answer digests for single-block, chained and re-initialised hashes check the round arithmetic, the schedule and the chaining.

// File: rtl/sha_acc_pkg.sv
package sha_acc_pkg;

    localparam int WORD_W       = 32;
    localparam int BLOCK_WORDS  = 16;
    localparam int DIGEST_WORDS = 8;
    localparam int BLOCK_W      = WORD_W * BLOCK_WORDS;
    localparam int DIGEST_W     = WORD_W * DIGEST_WORDS;
    localparam int ROUNDS       = 64;
    localparam int RND_W        = $clog2(ROUNDS);

    // Word addresses (software-visible map)
    localparam logic [7:0] A_ID_LO   = 8'h00;
    localparam logic [7:0] A_ID_HI   = 8'h01;
    localparam logic [7:0] A_VER     = 8'h02;
    localparam logic [7:0] A_CTRL    = 8'h08;
    localparam logic [7:0] A_STAT    = 8'h09;
    localparam logic [7:0] A_BLK_LO  = 8'h10;
    localparam logic [7:0] A_BLK_HI  = 8'h1F;
    localparam logic [7:0] A_DIG_LO  = 8'h20;
    localparam logic [7:0] A_DIG_HI  = 8'h27;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a, b, c, d, e, f, g, h;
    } work_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ROUND = 2'd1,
        ENG_FOLD  = 2'd2
    } eng_state_e;

    localparam word_t K_TAB [ROUNDS] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    localparam work_t IV = '{
        a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
        e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19
    };

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t sig_big0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t sig_big1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sig_sm0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sig_sm1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t f_choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t f_major(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic work_t fold_add(input work_t p, input work_t q);
        work_t r;
        r.a = p.a + q.a; r.b = p.b + q.b; r.c = p.c + q.c; r.d = p.d + q.d;
        r.e = p.e + q.e; r.f = p.f + q.f; r.g = p.g + q.g; r.h = p.h + q.h;
        return r;
    endfunction

endpackage

// File: rtl/sha_msg_sched.sv
module sha_msg_sched
    import sha_acc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               advance,
    input  logic [BLOCK_W-1:0] block,
    output word_t              w_cur
);
    word_t win [BLOCK_WORDS];
    word_t w_new;

    assign w_new = sig_sm1(win[BLOCK_WORDS-2]) + win[BLOCK_WORDS-7]
                 + sig_sm0(win[1]) + win[0];
    assign w_cur = win[0];

    genvar i;
    generate
        for (i = 0; i < BLOCK_WORDS; i++) begin : g_lane
            word_t lane_q;
            word_t lane_in;
            if (i < BLOCK_WORDS - 1) begin : g_mid
                assign lane_in = win[i+1];
            end else begin : g_top
                assign lane_in = w_new;
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    lane_q <= '0;
                end else if (load) begin
                    lane_q <= block[BLOCK_W-1-i*WORD_W -: WORD_W];
                end else if (advance) begin
                    lane_q <= lane_in;
                end
            end
            assign win[i] = lane_q;
        end
    endgenerate

endmodule

// File: rtl/sha_compress.sv
module sha_compress
    import sha_acc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               chain,
    input  logic [BLOCK_W-1:0] block,
    output logic               ready,
    output logic               valid,
    output work_t              digest_q
);
    eng_state_e       st;
    logic [RND_W-1:0] rnd;
    work_t            wv, wv_nxt, base;
    word_t            w_cur, t1, t2;
    logic             start_ok;

    assign start_ok = start && (st == ENG_IDLE);
    assign ready    = (st == ENG_IDLE);
    assign base     = chain ? digest_q : IV;

    sha_msg_sched u_sched (
        .clk     (clk),
        .rst     (rst),
        .load    (start_ok),
        .advance (st == ENG_ROUND),
        .block   (block),
        .w_cur   (w_cur)
    );

    always_comb begin
        t1 = wv.h + sig_big1(wv.e) + f_choose(wv.e, wv.f, wv.g) + K_TAB[rnd] + w_cur;
        t2 = sig_big0(wv.a) + f_major(wv.a, wv.b, wv.c);
        wv_nxt.a = t1 + t2;
        wv_nxt.b = wv.a;
        wv_nxt.c = wv.b;
        wv_nxt.d = wv.c;
        wv_nxt.e = wv.d + t1;
        wv_nxt.f = wv.e;
        wv_nxt.g = wv.f;
        wv_nxt.h = wv.g;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ENG_IDLE;
            rnd      <= '0;
            wv       <= '0;
            digest_q <= '0;
            valid    <= 1'b0;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (start_ok) begin
                        wv       <= base;
                        digest_q <= base;
                        rnd      <= '0;
                        valid    <= 1'b0;
                        st       <= ENG_ROUND;
                    end
                end
                ENG_ROUND: begin
                    wv  <= wv_nxt;
                    rnd <= rnd + 1'b1;
                    if (rnd == RND_W'(ROUNDS - 1)) begin
                        st <= ENG_FOLD;
                    end
                end
                ENG_FOLD: begin
                    digest_q <= fold_add(digest_q, wv);
                    valid    <= 1'b1;
                    st       <= ENG_IDLE;
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    // R6
    accept_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> (!ready && !valid));
    // R6
    valid_only_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> ready);
    // R6
    fold_follows_last_round_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ENG_ROUND && rnd == RND_W'(ROUNDS - 1)) |=> (st == ENG_FOLD));
    // R7
    digest_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ENG_IDLE && !start) |=> $stable(digest_q));

endmodule

// File: rtl/sha_bus_decode.sv
module sha_bus_decode
    import sha_acc_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [63:0] ID_NAME = "hashcore",
    parameter logic [31:0] ID_VER  = "v1.0"
) (
    input  logic                stb,
    input  logic                we,
    input  logic [ADDR_W-1:0]   adr,
    input  logic [1:0]          ctrl,
    input  logic                ready,
    input  logic                valid,
    input  logic [BLOCK_W-1:0]  block,
    input  logic [DIGEST_W-1:0] digest,
    output word_t               rdata,
    output logic                ack,
    output logic                err,
    output logic                wr_ctrl,
    output logic                wr_blk
);
    logic is_id, is_ctrl, is_stat, is_blk, is_dig;
    logic readable, writable;
    int   bidx, didx;

    always_comb begin
        is_id    = adr <= ADDR_W'(A_VER);
        is_ctrl  = adr == ADDR_W'(A_CTRL);
        is_stat  = adr == ADDR_W'(A_STAT);
        is_blk   = (adr >= ADDR_W'(A_BLK_LO)) && (adr <= ADDR_W'(A_BLK_HI));
        is_dig   = (adr >= ADDR_W'(A_DIG_LO)) && (adr <= ADDR_W'(A_DIG_HI));
        readable = is_id || is_ctrl || is_stat || is_blk || is_dig;
        writable = is_ctrl || is_blk;
        err      = stb && (we ? !writable : !readable);
        ack      = stb && !err;
        wr_ctrl  = stb && we && is_ctrl;
        wr_blk   = stb && we && is_blk;
        bidx     = int'(adr[3:0]);
        didx     = int'(adr[2:0]);
        rdata    = '0;
        if (stb && !we) begin
            if (adr == ADDR_W'(A_ID_LO))      rdata = ID_NAME[63:32];
            else if (adr == ADDR_W'(A_ID_HI)) rdata = ID_NAME[31:0];
            else if (adr == ADDR_W'(A_VER))   rdata = ID_VER;
            else if (is_ctrl)                 rdata = {30'b0, ctrl};
            else if (is_stat)                 rdata = {30'b0, valid, ready};
            else if (is_blk)                  rdata = block[(BLOCK_WORDS-1-bidx)*WORD_W +: WORD_W];
            else if (is_dig)                  rdata = digest[(DIGEST_WORDS-1-didx)*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/sha_hash_accel.sv
module sha_hash_accel
    import sha_acc_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [63:0] ID_NAME = "hashcore",
    parameter logic [31:0] ID_VER  = "v1.0"
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [31:0]       dat_i,
    output logic [31:0]       dat_o,
    output logic              ack_o,
    output logic              err_o
);
    logic [BLOCK_W-1:0] blk_q;
    logic [1:0]         ctrl_q;
    logic [1:0]         rise;
    logic               wr_ctrl, wr_blk;
    logic               ready, valid, start, chain;
    work_t              digest;
    int                 widx;

    assign rise  = wr_ctrl ? (dat_i[1:0] & ~ctrl_q) : 2'b00;
    assign start = (rise != 2'b00) && ready;
    assign chain = !rise[0];
    assign widx  = int'(adr_i[3:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= dat_i[1:0];
            if (wr_blk)  blk_q[(BLOCK_WORDS-1-widx)*WORD_W +: WORD_W] <= dat_i;
        end
    end

    sha_bus_decode #(
        .ADDR_W  (ADDR_W),
        .ID_NAME (ID_NAME),
        .ID_VER  (ID_VER)
    ) u_dec (
        .stb     (stb_i),
        .we      (we_i),
        .adr     (adr_i),
        .ctrl    (ctrl_q),
        .ready   (ready),
        .valid   (valid),
        .block   (blk_q),
        .digest  (digest),
        .rdata   (dat_o),
        .ack     (ack_o),
        .err     (err_o),
        .wr_ctrl (wr_ctrl),
        .wr_blk  (wr_blk)
    );

    sha_compress u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .chain    (chain),
        .block    (blk_q),
        .ready    (ready),
        .valid    (valid),
        .digest_q (digest)
    );

    // R8
    refused_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_i && !we_i && err_o) |-> (dat_o == 32'h0));
    // R8
    one_response_chk: assert property (@(posedge clk) disable iff (rst)
        stb_i |-> $onehot({ack_o, err_o}));
    // R8
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !stb_i |-> (!ack_o && !err_o));
    // R5
    held_bit_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && ready && ((dat_i[1:0] & ~ctrl_q) == 2'b00)) |=> ready);
    // R9
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && wr_ctrl) |=> $stable(digest));

endmodule

// File: tb/sim_sha_hash_accel.sv
module sim_sha_hash_accel;

    logic        clk = 1'b0;
    logic        rst;
    logic        stb, we;
    logic [7:0]  adr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        ack, err;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    sha_hash_accel u0 (
        .clk(clk), .rst(rst), .stb_i(stb), .we_i(we), .adr_i(adr),
        .dat_i(wd), .dat_o(rd), .ack_o(ack), .err_o(err)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic [7:0]  a;
        logic        w;
        logic [31:0] d;
        logic        xerr;
        logic        cmp;
        logic [31:0] xd;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{8'd1, 8'h00, 1'b0, 32'h0,        1'b0, 1'b1, 32'h68617368}, // R1
        '{8'd1, 8'h01, 1'b0, 32'h0,        1'b0, 1'b1, 32'h636f7265}, // R1
        '{8'd1, 8'h02, 1'b0, 32'h0,        1'b0, 1'b1, 32'h76312e30}, // R1
        '{8'd6, 8'h09, 1'b0, 32'h0,        1'b0, 1'b1, 32'h00000001}, // R6 reset status
        '{8'd7, 8'h20, 1'b0, 32'h0,        1'b0, 1'b1, 32'h0},        // R7
        '{8'd7, 8'h27, 1'b0, 32'h0,        1'b0, 1'b1, 32'h0},        // R7
        '{8'd2, 8'h10, 1'b1, 32'hdeadbeef, 1'b0, 1'b0, 32'h0},        // R2
        '{8'd2, 8'h10, 1'b0, 32'h0,        1'b0, 1'b1, 32'hdeadbeef}, // R2
        '{8'd2, 8'h1F, 1'b1, 32'h0badf00d, 1'b0, 1'b0, 32'h0},        // R2
        '{8'd2, 8'h1F, 1'b0, 32'h0,        1'b0, 1'b1, 32'h0badf00d}, // R2
        '{8'd8, 8'h05, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0},        // R8
        '{8'd8, 8'h30, 1'b0, 32'h0,        1'b1, 1'b1, 32'h0},        // R8
        '{8'd8, 8'h20, 1'b1, 32'hcafef00d, 1'b1, 1'b0, 32'h0},        // R8
        '{8'd8, 8'h20, 1'b0, 32'h0,        1'b0, 1'b1, 32'h0},        // R8 write ignored
        '{8'd8, 8'h09, 1'b1, 32'h3,        1'b1, 1'b0, 32'h0},        // R8
        '{8'd8, 8'h09, 1'b0, 32'h0,        1'b0, 1'b1, 32'h00000001}, // R8 write ignored
        '{8'd8, 8'h44, 1'b1, 32'h1,        1'b1, 1'b0, 32'h0},        // R8
        '{8'd5, 8'h08, 1'b0, 32'h0,        1'b0, 1'b1, 32'h0}         // R5
    };

    localparam logic [511:0] BLK_ABC = {32'h61626380, 448'h0, 32'h18};
    localparam logic [511:0] BLK_TWO_A =
        512'h6162636462636465636465666465666765666768666768696768696A68696A6B696A6B6C6A6B6C6D6B6C6D6E6C6D6E6F6D6E6F706E6F70718000000000000000;
    localparam logic [511:0] BLK_TWO_B = {480'h0, 32'h1C0};
    localparam logic [511:0] BLK_JUNK  = {16{32'hA5A55A5A}};
    localparam logic [255:0] DG_ABC =
        256'hBA7816BF8F01CFEA414140DE5DAE2223B00361A396177A9CB410FF61F20015AD;
    localparam logic [255:0] DG_MID =
        256'h85E655D6417A17953363376A624CDE5C76E09589CAC5F811CC4B32C1F20E533A;
    localparam logic [255:0] DG_END =
        256'h248D6A61D20638B8E5C026930C3E6039A33CE45964FF2167F6ECEDD419DB06C1;

    task automatic chk(input bit ok, input string rq, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic bus(input logic [7:0] a, input logic w, input logic [31:0] d,
                       output logic [31:0] r, output logic e);
        @(negedge clk);
        stb = 1'b1; we = w; adr = a; wd = d;
        #4;
        r = rd; e = err;
        @(posedge clk);
        #1;
        stb = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] r; logic e;
        bus(a, 1'b1, d, r, e);
    endtask

    task automatic rdw(input logic [7:0] a, output logic [31:0] r);
        logic e;
        bus(a, 1'b0, 32'h0, r, e);
    endtask

    task automatic load_block(input logic [511:0] b);
        for (int i = 0; i < 16; i++) wr(8'h10 + 8'(i), b[511-32*i -: 32]);
    endtask

    task automatic get_digest(output logic [255:0] dg);
        logic [31:0] w;
        for (int i = 0; i < 8; i++) begin
            rdw(8'h20 + 8'(i), w);
            dg[255-32*i -: 32] = w;
        end
    endtask

    task automatic wait_ready(output int polls);
        logic [31:0] s;
        polls = 0;
        do begin
            rdw(8'h09, s);
            polls++;
        end while (!s[0] && polls < 300);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0]  r;
        logic         e;
        logic [255:0] dg;
        int           polls;

        rst = 1'b1; stb = 1'b0; we = 1'b0; adr = '0; wd = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Register map vectors
        for (int i = 0; i < NV; i++) begin
            bus(VT[i].a, VT[i].w, VT[i].d, r, e);
            chk((e == VT[i].xerr) && (!VT[i].cmp || r == VT[i].xd),
                $sformatf("R%0d vec%0d", VT[i].rq, i),
                {223'h0, e, r}, {223'h0, VT[i].xerr, VT[i].xd});
        end

        // R3: single block from initial values
        load_block(BLK_ABC);
        wr(8'h08, 32'h1);
        wait_ready(polls);
        chk(polls == 66, "R6 busy length", 256'(polls), 256'd66);
        get_digest(dg);
        chk(dg == DG_ABC, "R3 abc digest", dg, DG_ABC);
        rdw(8'h09, r);
        chk(r == 32'h3, "R6 ready+valid", 256'(r), 256'h3);

        // R5: rewriting a held 1 starts nothing
        wr(8'h08, 32'h1);
        rdw(8'h09, r);
        chk(r == 32'h3, "R5 held bit no restart", 256'(r), 256'h3);
        rdw(8'h08, r);
        chk(r == 32'h1, "R5 ctrl readback", 256'(r), 256'h1);
        wr(8'h08, 32'h0);

        // R4: chained two-block hash
        load_block(BLK_TWO_A);
        wr(8'h08, 32'h1);
        rdw(8'h09, r);
        chk(r == 32'h0, "R6 status cleared on accept", 256'(r), 256'h0);
        wait_ready(polls);
        wr(8'h08, 32'h0);
        get_digest(dg);
        chk(dg == DG_MID, "R4 first block digest", dg, DG_MID);
        load_block(BLK_TWO_B);
        wr(8'h08, 32'h2);
        wait_ready(polls);
        wr(8'h08, 32'h0);
        get_digest(dg);
        chk(dg == DG_END, "R4 chained digest", dg, DG_END);

        // R3: init discards the held digest
        load_block(BLK_ABC);
        wr(8'h08, 32'h1);
        wait_ready(polls);
        wr(8'h08, 32'h0);
        get_digest(dg);
        chk(dg == DG_ABC, "R3 init restarts from IV", dg, DG_ABC);

        // R9 / R2: block rewrite and commands during busy have no effect
        wr(8'h08, 32'h1);
        load_block(BLK_JUNK);
        wr(8'h08, 32'h0);
        wr(8'h08, 32'h2);
        wr(8'h08, 32'h0);
        wait_ready(polls);
        get_digest(dg);
        chk(dg == DG_ABC, "R9 busy command ignored", dg, DG_ABC);
        rdw(8'h15, r);
        chk(r == 32'hA5A55A5A, "R2 block written while busy", 256'(r), 256'hA5A55A5A);

        // R6 / R7: reset during a hash
        load_block(BLK_ABC);
        wr(8'h08, 32'h1);
        rdw(8'h09, r);
        rdw(8'h09, r);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rdw(8'h09, r);
        chk(r == 32'h1, "R6 status after reset", 256'(r), 256'h1);
        get_digest(dg);
        chk(dg == 256'h0, "R7 digest after reset", dg, 256'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule